// File: doc/BRIEF.md
# I2C Controller Interrupt Collector with Abort Cause Capture

This block gathers the event indications of an I2C controller into one status word, gates that word with a software mask and drives a single level interrupt line. Ten of the twelve sources are sticky: a one-cycle pulse from the bus engine sets a bit that stays set until software reads a clearing address. Software can read one address to clear every sticky bit at once, or one address per event to clear just that bit. The remaining two sources, receive-full and transmit-empty, are not stored. They are recomputed every cycle by comparing the FIFO fill levels against two programmable thresholds.

A separate 16-bit abort cause word records why a transfer was abandoned. The engine ORs cause bits into it, and a read of its clearing address empties it. A read of a clearing address takes effect at the next clock edge. An event that arrives in that same cycle wins and remains set.

Top module: `evt_irq_top`

## Requirements
- R1: After reset the sticky events, the mask, both thresholds and the abort cause word are zero and `irqOut` is low. The status read at address 0 then shows only the transmit-empty level bit, so it reads 0x010 while `txLevel` is 0.
- R2: A pulse on `evtPulse[n]` for a sticky bit n sets status bit n from the next cycle on. The status bit order is: 0 receive underflow, 1 receive overflow, 2 receive full, 3 transmit overflow, 4 transmit empty, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop seen, 10 start seen, 11 general call. Pulses on bits 2 and 4 are ignored.
- R3: `irqOut` is the OR over all bits of (status AND mask). The mask is written at address 1, a mask bit of 1 enables its source, and the mask reads back at address 1.
- R4: A read of address 4 clears every sticky event bit at the next edge and returns 0. The abort cause word is not affected.
- R5: A read of address 8+n clears only sticky bit n and returns 0. This holds for n in {0,1,3,5,6,7,8,9,10,11}.
- R6: The abort cause word reads at address 5. It accumulates by OR of `abortPulse`, and a read of address 6 clears it. Its bits are: 0 7-bit address NACK, 1 10-bit address first byte NACK, 2 10-bit address second byte NACK, 3 data NACK, 4 general call NACK, 5 general call read, 6 high-speed code ACKed, 7 start byte ACKed, 8 high speed with no restart, 9 start byte with no restart, 10 10-bit read with no restart, 11 controller disabled, 12 arbitration lost, 13 target TX flush, 14 target arbitration lost, 15 target read while TX.
- R7: Status bit 2 is 1 exactly while `rxLevel` is greater than the receive threshold. The receive threshold is written and read at address 2, so writing N-1 makes bit 2 assert at N bytes.
- R8: Status bit 4 is 1 exactly while `txLevel` is at or below the transmit threshold, which is written and read at address 3. No clearing read changes bit 2 or bit 4.
- R9: An event pulse or abort cause pulse in the same cycle as a read that clears it leaves that bit set.
- R10: Reads of unmapped addresses (for example 10) and of clearing addresses return 0. A read of an unmapped address clears nothing, and a write to address 0 or to any clearing address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 12 | One-cycle event pulses from the bus engine, bit order as in R2 |
| abortPulse | input | 16 | Abort cause bits to OR into the cause word |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| txLevel | input | LVL_W | Transmit FIFO fill level |
| regSel | input | ADDR_W | Register address |
| regRd | input | 1 | Read strobe; clearing addresses act at the edge |
| regWr | input | 1 | Write strobe |
| regWdata | input | 12 | Write data |
| regRdata | output | 16 | Read data for `regSel`, valid in the same cycle |
| irqOut | output | 1 | Level interrupt |

## Verification
The bench uses several kinds of stimulus. A burst of all twelve pulses separates sticky bits from the two level bits. Single-bit and whole-word clears show whether a clear reaches only its own bit. Rising and falling FIFO levels around each threshold locate the exact comparison edge, strict for receive and inclusive for transmit. Pulses placed in the same cycle as a clearing read show which of the two takes priority. A behavioural model checks the interrupt line after every clock.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int EVT_N = 12;
  localparam int ABT_N = 16;
  localparam int RD_W  = 16;

  localparam int BIT_RXFULL  = 2;
  localparam int BIT_TXEMPTY = 4;

  // sticky sources: every event except the two level-driven ones
  localparam logic [EVT_N-1:0] STICKY = ~((EVT_N'(1) << BIT_RXFULL) | (EVT_N'(1) << BIT_TXEMPTY));

  localparam int ADDR_STATUS  = 0;
  localparam int ADDR_MASK    = 1;
  localparam int ADDR_RXTHR   = 2;
  localparam int ADDR_TXTHR   = 3;
  localparam int ADDR_CLRALL  = 4;
  localparam int ADDR_ABTSRC  = 5;
  localparam int ADDR_ABTCLR  = 6;
  localparam int ADDR_CLRBASE = 8;

  typedef struct packed {
    logic [EVT_N-1:0] evtClr;
    logic             abtClr;
    logic             maskWe;
    logic             rxThrWe;
    logic             txThrWe;
  } strobe_t;
endpackage

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regRd,
  input  logic              regWr,
  output strobe_t           strobe
);
  logic [EVT_N-1:0] singleHit;
  logic             clrAll;

  assign clrAll = regRd && (regSel == ADDR_W'(ADDR_CLRALL));

  for (genvar i = 0; i < EVT_N; i++) begin : g_clr
    if (STICKY[i]) begin : g_on
      assign singleHit[i] = regRd && (regSel == ADDR_W'(ADDR_CLRBASE + i));
    end else begin : g_off
      assign singleHit[i] = 1'b0;
    end
  end

  always_comb begin
    strobe.evtClr  = singleHit | {EVT_N{clrAll}};
    strobe.abtClr  = regRd && (regSel == ADDR_W'(ADDR_ABTCLR));
    strobe.maskWe  = regWr && (regSel == ADDR_W'(ADDR_MASK));
    strobe.rxThrWe = regWr && (regSel == ADDR_W'(ADDR_RXTHR));
    strobe.txThrWe = regWr && (regSel == ADDR_W'(ADDR_TXTHR));
  end
endmodule

// File: rtl/evt_irq_data.sv
module evt_irq_data
  import evt_irq_pkg::*;
#(
  parameter int LVL_W  = 5,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [EVT_N-1:0]  evtPulse,
  input  logic [ABT_N-1:0]  abortPulse,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [ADDR_W-1:0] regSel,
  input  logic [EVT_N-1:0]  regWdata,
  output logic [RD_W-1:0]   regRdata,
  output logic [EVT_N-1:0]  statusVal,
  output logic [EVT_N-1:0]  maskVal,
  output logic [ABT_N-1:0]  abortSrc,
  output logic              irqOut
);
  logic [EVT_N-1:0] sticky;
  logic [LVL_W-1:0] rxThr;
  logic [LVL_W-1:0] txThr;
  logic             rxFull;
  logic             txEmpty;

  for (genvar i = 0; i < EVT_N; i++) begin : g_evt
    if (STICKY[i]) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rstN)                sticky[i] <= 1'b0;
        else if (evtPulse[i])     sticky[i] <= 1'b1;
        else if (strobe.evtClr[i]) sticky[i] <= 1'b0;
      end
    end else begin : g_lvl
      assign sticky[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      abortSrc <= '0;
      maskVal  <= '0;
      rxThr    <= '0;
      txThr    <= '0;
    end else begin
      abortSrc <= (strobe.abtClr ? '0 : abortSrc) | abortPulse;
      if (strobe.maskWe)  maskVal <= regWdata;
      if (strobe.rxThrWe) rxThr   <= regWdata[LVL_W-1:0];
      if (strobe.txThrWe) txThr   <= regWdata[LVL_W-1:0];
    end
  end

  assign rxFull  = rxLevel > rxThr;
  assign txEmpty = txLevel <= txThr;

  always_comb begin
    statusVal              = sticky;
    statusVal[BIT_RXFULL]  = rxFull;
    statusVal[BIT_TXEMPTY] = txEmpty;
  end

  assign irqOut = |(statusVal & maskVal);

  always_comb begin
    case (regSel)
      ADDR_W'(ADDR_STATUS): regRdata = RD_W'(statusVal);
      ADDR_W'(ADDR_MASK):   regRdata = RD_W'(maskVal);
      ADDR_W'(ADDR_RXTHR):  regRdata = RD_W'(rxThr);
      ADDR_W'(ADDR_TXTHR):  regRdata = RD_W'(txThr);
      ADDR_W'(ADDR_ABTSRC): regRdata = RD_W'(abortSrc);
      default:              regRdata = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_top.sv
module evt_irq_top
  import evt_irq_pkg::*;
#(
  parameter int LVL_W  = 5,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [11:0]       evtPulse,
  input  logic [15:0]       abortPulse,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  txLevel,
  input  logic [ADDR_W-1:0] regSel,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [11:0]       regWdata,
  output logic [15:0]       regRdata,
  output logic              irqOut
);
  strobe_t          strobe;
  logic [EVT_N-1:0] statusVal;
  logic [EVT_N-1:0] maskVal;
  logic [ABT_N-1:0] abortSrc;

  evt_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .regSel (regSel),
    .regRd  (regRd),
    .regWr  (regWr),
    .strobe (strobe)
  );

  evt_irq_data #(.LVL_W(LVL_W), .ADDR_W(ADDR_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .evtPulse   (evtPulse),
    .abortPulse (abortPulse),
    .rxLevel    (rxLevel),
    .txLevel    (txLevel),
    .regSel     (regSel),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .statusVal  (statusVal),
    .maskVal    (maskVal),
    .abortSrc   (abortSrc),
    .irqOut     (irqOut)
  );
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [EVT_N-1:0]  evtPulse,
  input logic [ABT_N-1:0]  abortPulse,
  input logic [ADDR_W-1:0] regSel,
  input logic              regRd,
  input logic [EVT_N-1:0]  statusVal,
  input logic [EVT_N-1:0]  maskVal,
  input logic [ABT_N-1:0]  abortSrc,
  input logic              irqOut
);
  // R2 and R9: a sticky pulse is always visible next cycle, clear or not
  assert_pulse_sticks_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((evtPulse & STICKY) != '0) |=>
      ((statusVal & $past(evtPulse & STICKY)) == $past(evtPulse & STICKY)));

  // R4: clear-all with no new events empties the sticky part
  assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regSel == ADDR_W'(ADDR_CLRALL) && (evtPulse & STICKY) == '0) |=>
      ((statusVal & STICKY) == '0));

  // R6: abort clear with no new cause empties the word
  assert_abort_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRd && regSel == ADDR_W'(ADDR_ABTCLR) && abortPulse == '0) |=> (abortSrc == '0));

  // R6: without pulse or clear the abort word holds
  assert_abort_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (abortPulse == '0 && !(regRd && regSel == ADDR_W'(ADDR_ABTCLR))) |=> $stable(abortSrc));

  // R3: a zero mask keeps the line low
  assert_mask_gates_R3: assert property (@(posedge clk) disable iff (!rstN)
    (maskVal == '0) |-> !irqOut);
endmodule

bind evt_irq_top evt_irq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .evtPulse   (evtPulse),
  .abortPulse (abortPulse),
  .regSel     (regSel),
  .regRd      (regRd),
  .statusVal  (statusVal),
  .maskVal    (maskVal),
  .abortSrc   (abortSrc),
  .irqOut     (irqOut)
);

// File: tb/sim_evt_irq_top.sv
`timescale 1ns/1ps
module sim_evt_irq_top;
  localparam int LW = 5;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [11:0]   evtPulse = '0;
  logic [15:0]   abortPulse = '0;
  logic [LW-1:0] rxLevel = '0;
  logic [LW-1:0] txLevel = '0;
  logic [AW-1:0] regSel = '0;
  logic          regRd = 1'b0;
  logic          regWr = 1'b0;
  logic [11:0]   regWdata = '0;
  logic [15:0]   regRdata;
  logic          irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [15:0] lastRd;

  always #5 clk = ~clk;

  evt_irq_top #(.LVL_W(LW), .ADDR_W(AW)) u0 (.*);

  // behavioural reference state
  logic [11:0]   mLat, mMask;
  logic [LW-1:0] mRxThr, mTxThr;
  logic [15:0]   mAbt;

  function automatic bit isSticky(int n);
    return (n >= 0) && (n < 12) && (n != 2) && (n != 4);
  endfunction

  function automatic logic [11:0] mStatus();
    logic [11:0] s;
    s = mLat;
    s[2] = (int'(rxLevel) > int'(mRxThr));
    s[4] = (int'(txLevel) <= int'(mTxThr));
    return s;
  endfunction

  function automatic logic mIrq();
    return (mStatus() & mMask) != 0;
  endfunction

  function automatic logic [15:0] mRead(int sel);
    case (sel)
      0: return {4'h0, mStatus()};
      1: return {4'h0, mMask};
      2: return 16'(mRxThr);
      3: return 16'(mTxThr);
      5: return mAbt;
      default: return 16'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [11:0] clr;
    if (!rstN) begin
      mLat <= 0; mMask <= 0; mRxThr <= 0; mTxThr <= 0; mAbt <= 0;
    end else begin
      clr = 0;
      if (regRd && int'(regSel) == 4) clr = 12'hFFF;
      if (regRd && isSticky(int'(regSel) - 8)) clr[int'(regSel) - 8] = 1'b1;
      for (int i = 0; i < 12; i++)
        if (isSticky(i)) mLat[i] <= evtPulse[i] ? 1'b1 : (clr[i] ? 1'b0 : mLat[i]);
      mAbt <= ((regRd && int'(regSel) == 6) ? 16'h0 : mAbt) | abortPulse;
      if (regWr && int'(regSel) == 1) mMask  <= regWdata;
      if (regWr && int'(regSel) == 2) mRxThr <= regWdata[LW-1:0];
      if (regWr && int'(regSel) == 3) mTxThr <= regWdata[LW-1:0];
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    if (rstN) begin
      checks++;
      if (irqOut !== mIrq()) begin
        errors++;
        $display("FAIL R3 irq per-cycle actual=%0b expected=%0b", irqOut, mIrq());
      end
    end
  endtask

  task automatic expectVal(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic readChk(int sel, string tag);
    regSel = AW'(sel);
    regRd = 1'b1;
    #1;
    lastRd = regRdata;
    expectVal(tag, regRdata, mRead(sel));
    step();
    regRd = 1'b0;
    evtPulse = '0;
    abortPulse = '0;
  endtask

  task automatic wr(int sel, logic [11:0] d);
    regSel = AW'(sel); regWdata = d; regWr = 1'b1;
    step();
    regWr = 1'b0;
  endtask

  task automatic pulse(logic [11:0] e, logic [15:0] a);
    evtPulse = e; abortPulse = a;
    step();
    evtPulse = '0; abortPulse = '0;
  endtask

  initial begin
    repeat (3) step();
    #1 rstN = 1'b1;
    step();
    // R1 reset state
    readChk(0, "R1 status after reset");  expectVal("R1 status literal", lastRd, 16'h0010);
    readChk(1, "R1 mask after reset");    expectVal("R1 mask literal", lastRd, 16'h0);
    readChk(5, "R1 abort after reset");   expectVal("R1 abort literal", lastRd, 16'h0);
    expectVal("R1 irq low", {15'h0, irqOut}, 16'h0);
    // R2 all pulses, level bits ignored
    pulse(12'hFFF, 16'h0);
    readChk(0, "R2 status latched");      expectVal("R2 literal", lastRd, 16'h0FFB);
    // R3 mask and R5 single clear
    wr(1, 12'h001);
    expectVal("R3 irq high", {15'h0, irqOut}, 16'h1);
    readChk(1, "R3 mask readback");
    readChk(8, "R5 clear bit0 returns 0"); expectVal("R5 clear read zero", lastRd, 16'h0);
    expectVal("R5 irq low after clear", {15'h0, irqOut}, 16'h0);
    readChk(0, "R5 others kept");         expectVal("R5 literal", lastRd, 16'h0FFA);
    // R4 clear all
    pulse(12'h000, 16'h0003);
    readChk(4, "R4 clear-all returns 0");
    readChk(0, "R4 status after clear");  expectVal("R4 literal", lastRd, 16'h0010);
    // R6 abort accumulation and clear
    pulse(12'h000, 16'h8000);
    readChk(5, "R6 abort accum");         expectVal("R6 literal", lastRd, 16'h8003);
    readChk(6, "R6 abort clear read");
    readChk(5, "R6 abort cleared");       expectVal("R6 cleared literal", lastRd, 16'h0);
    // R7 receive threshold
    wr(2, 12'h003);
    readChk(2, "R7 rx threshold readback");
    rxLevel = 3; step();
    readChk(0, "R7 rx at thr");           expectVal("R7 at thr literal", lastRd, 16'h0010);
    rxLevel = 4; step();
    readChk(0, "R7 rx above thr");        expectVal("R7 above literal", lastRd, 16'h0014);
    wr(1, 12'h004);
    expectVal("R7 irq from rx full", {15'h0, irqOut}, 16'h1);
    readChk(4, "R8 clear-all on level");
    readChk(0, "R8 level survives clear"); expectVal("R8 level literal", lastRd, 16'h0014);
    rxLevel = 0; step();
    // R8 transmit threshold
    wr(3, 12'h002);
    txLevel = 3; step();
    readChk(0, "R8 tx above thr");        expectVal("R8 above literal", lastRd, 16'h0000);
    txLevel = 2; step();
    readChk(0, "R8 tx at thr");           expectVal("R8 at literal", lastRd, 16'h0010);
    // R9 coincident event and clear
    evtPulse = 12'h001; readChk(8, "R9 single clear vs pulse");
    readChk(0, "R9 bit0 kept");           expectVal("R9 single literal", lastRd, 16'h0011);
    evtPulse = 12'h200; readChk(4, "R9 clear-all vs pulse");
    readChk(0, "R9 bit9 kept");           expectVal("R9 all literal", lastRd, 16'h0210);
    abortPulse = 16'h0010; readChk(6, "R9 abort clear vs pulse");
    readChk(5, "R9 abort kept");          expectVal("R9 abort literal", lastRd, 16'h0010);
    // R10 unmapped, clear-address reads, ignored writes
    readChk(10, "R10 unmapped read");     expectVal("R10 unmapped zero", lastRd, 16'h0);
    readChk(0, "R10 nothing cleared");    expectVal("R10 kept literal", lastRd, 16'h0210);
    wr(0, 12'hFFF);
    wr(17, 12'hFFF);
    readChk(0, "R10 write ignored");      expectVal("R10 write literal", lastRd, 16'h0210);
    readChk(1, "R10 mask unchanged");     expectVal("R10 mask literal", lastRd, 16'h0004);
    repeat (3) step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule